// File: doc/BRIEF.md
# DRAM Compressed Test-Mode Controller

This block is a synthesizable cycle-level model of the test-mode logic inside a x4 dynamic memory. Each data pin has four internal storage blocks behind it. The block samples the active-low row strobe, column strobe and write strobe, plus a multiplexed address bus, on every clock. From the relative order of the strobe edges it recognises access cycles and refresh cycles.

The write-and-column-before-row cycle, with a fixed address pattern, puts the block into a compressed test mode. In that mode a write copies each pin's bit into all four of its blocks. A read reports, per pin, whether the four blocks agree. Any plain refresh cycle returns the block to normal operation.

In normal operation the two low column address bits choose the block a pin talks to. This makes it possible to load differing data into a pin's four blocks and then prove that the compare reports the difference. The array depth is set by parameters.

Top module: `dtm_top`

## Requirements
- R1: When the row strobe falls while the column strobe and write strobe are already low, and address bits 0 through 9 are all 1, `test_mode` reads 1 from the next clock on. Address bits 10 and above play no part in this decision.
- R2: The same strobe order with any of address bits 0 through 9 at 0 is treated as an ordinary column-before-row refresh. `test_mode` is 0 afterwards, whether or not it was set before.
- R3: In test mode, a write (column strobe falling while the row strobe is low and the write strobe is low) stores `din[p]` into all four blocks of pin p. The target word is chosen by the latched row and column bits 2 and up. Column bits 1:0 are ignored.
- R4: In test mode, a read returns `dout[p]` = 1 when the four blocks of pin p hold equal bits, and 0 when they differ.
- R5: In normal mode, column bits 1:0 give the block number b. A write changes only block b of each pin, and a read returns block b of each pin.
- R6: A column-before-row refresh with the write strobe high clears `test_mode`. So does a hidden refresh: the column strobe is held low after a read while the row strobe rises and falls again.
- R7: A row-strobe-only cycle clears `test_mode`. In such a cycle the row strobe goes low and back high with no column strobe fall between the two edges.
- R8: While in test mode, read cycles and further pattern-matching entry cycles leave `test_mode` at 1.
- R9: Read data appears on `dout` at the clock edge that samples the column strobe fall. `dout_vld` is 1 for exactly that one cycle. `dout` then holds its value until the next read; writes do not change it.
- R10: After reset, `test_mode`, `dout` and `dout_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | PINS | Write data, one bit per pin |
| dout | output | PINS | Read data or per-pin compare result |
| dout_vld | output | 1 | One-cycle pulse when a read lands on dout |
| test_mode | output | 1 | 1 while compressed test mode is active |

## Verification
Two functions can fall in the same clock edge: the row strobe rising at the end of a test-mode read, and the column strobe still being low from that read. The following row-strobe fall must then be classed as a refresh that exits test mode, not as a new access.

The bench provokes this with a hidden refresh. It takes the compare result during the read, and it checks that `test_mode` drops only after the second row-strobe fall. A further pair of cases separates the two kinds of entry cycle: one address differs from the entry pattern by a single low bit, the other has the bits above the pattern set. The bench judges each case by `test_mode`.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  // four internal blocks behind every data pin
  localparam int unsigned BLK   = 4;
  localparam int unsigned BLK_W = 2;

  // what the current row-strobe-low interval turned out to be
  typedef enum logic [1:0] {
    RK_IDLE    = 2'd0,
    RK_ACCESS  = 2'd1,
    RK_REFRESH = 2'd2
  } row_kind_e;
endpackage

// File: rtl/dtm_strobe_sense.sv
module dtm_strobe_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall
);
  logic ras_q, cas_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
    end
  end

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
endmodule

// File: rtl/dtm_mode_ctl.sv
module dtm_mode_ctl
  import dtm_pkg::*;
#(
  parameter int unsigned PAT_W = 10,
  parameter int unsigned ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [PAT_W-1:0] addr_lo,
  input  logic             ras_fall,
  input  logic             ras_rise,
  input  logic             cas_fall,
  output logic             test_mode,
  output logic             acc_wr,
  output logic             acc_rd,
  output logic [ROW_W-1:0] row_q
);
  row_kind_e        kind_q, kind_d;
  logic             seen_q, seen_d;
  logic             tm_q, tm_d;
  logic [ROW_W-1:0] row_d;
  logic             pat_hit, acc_go;

  assign pat_hit = &addr_lo;
  assign acc_go  = cas_fall & ~ras_n & ~ras_fall & (kind_q == RK_ACCESS);

  // next-state
  always_comb begin
    kind_d = kind_q;
    seen_d = seen_q;
    tm_d   = tm_q;
    row_d  = row_q;
    if (ras_fall) begin
      if (!cas_n) begin
        kind_d = RK_REFRESH;
        tm_d   = ~we_n & pat_hit;
      end else begin
        kind_d = RK_ACCESS;
        seen_d = 1'b0;
        row_d  = addr_lo[ROW_W-1:0];
      end
    end else if (ras_rise) begin
      if (kind_q == RK_ACCESS && !seen_q) tm_d = 1'b0;
      kind_d = RK_IDLE;
    end else if (acc_go) begin
      seen_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RK_IDLE;
      seen_q <= 1'b0;
      tm_q   <= 1'b0;
      row_q  <= '0;
    end else begin
      kind_q <= kind_d;
      seen_q <= seen_d;
      tm_q   <= tm_d;
      row_q  <= row_d;
    end
  end

  assign test_mode = tm_q;
  assign acc_wr    = acc_go & ~we_n;
  assign acc_rd    = acc_go & we_n;

  assert_wcbr_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n && pat_hit) |=> test_mode);
  assert_wcbr_nomatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n && !pat_hit) |=> !test_mode);
  assert_cbr_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);
  assert_rasonly_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && kind_q == RK_ACCESS && !seen_q) |=> !test_mode);
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_fall && !ras_rise) |=> $stable(test_mode));
endmodule

// File: rtl/dtm_cell_array.sv
module dtm_cell_array
  import dtm_pkg::*;
#(
  parameter int unsigned PINS  = 4,
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [PINS-1:0]  din,
  output logic [PINS-1:0]  dout,
  output logic             dout_vld
);
  localparam int unsigned WORD_W = PINS * BLK;
  localparam int unsigned WIDX_W = ROW_W + COL_W - BLK_W;
  localparam int unsigned WORDS  = 1 << WIDX_W;

  logic [WORD_W-1:0] mem [WORDS];
  logic [WIDX_W-1:0] widx;
  logic [BLK_W-1:0]  sel;
  logic [WORD_W-1:0] cur, nxt;
  logic [PINS-1:0]   rd_bits;

  assign widx = {row, col[COL_W-1:BLK_W]};
  assign sel  = col[BLK_W-1:0];
  assign cur  = mem[widx];

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [BLK-1:0] nib;
    assign nib = cur[p*BLK +: BLK];
    // compressed compare: all ones or all zeros means pass
    assign rd_bits[p] = tst ? ((&nib) | ~(|nib)) : nib[sel];
    for (genvar b = 0; b < BLK; b++) begin : g_blk
      assign nxt[p*BLK+b] = (tst || sel == BLK_W'(b)) ? din[p] : nib[b];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_en;
      if (rd_en) dout <= rd_bits;
    end
  end

  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));
  assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(dout) && !dout_vld));
  assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> dout_vld);
endmodule

// File: rtl/dtm_top.sv
module dtm_top #(
  parameter int unsigned PINS   = 4,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 4,
  parameter int unsigned PAT_W  = 10,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   din,
  output logic [PINS-1:0]   dout,
  output logic              dout_vld,
  output logic              test_mode
);
  logic             ras_fall, ras_rise, cas_fall;
  logic             acc_wr, acc_rd;
  logic [ROW_W-1:0] row_q;

  if (ADDR_W > PAT_W) begin : g_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr[ADDR_W-1:PAT_W];
  end

  dtm_strobe_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ras_fall (ras_fall),
    .ras_rise (ras_rise),
    .cas_fall (cas_fall)
  );

  dtm_mode_ctl #(.PAT_W(PAT_W), .ROW_W(ROW_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr_lo   (addr[PAT_W-1:0]),
    .ras_fall  (ras_fall),
    .ras_rise  (ras_rise),
    .cas_fall  (cas_fall),
    .test_mode (test_mode),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .row_q     (row_q)
  );

  dtm_cell_array #(.PINS(PINS), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .tst      (test_mode),
    .wr_en    (acc_wr),
    .rd_en    (acc_rd),
    .row      (row_q),
    .col      (addr[COL_W-1:0]),
    .din      (din),
    .dout     (dout),
    .dout_vld (dout_vld)
  );
endmodule

// File: tb/sim_dtm_top.sv
`timescale 1ns/1ps
module sim_dtm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [3:0]  din = '0;
  logic [3:0]  dout;
  logic        dout_vld, test_mode;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dtm_top u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld), .test_mode(test_mode)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] row, input logic [3:0] col, input logic [3:0] d);
    addr = {9'd0, row}; ras_n = 1'b0; tick();
    addr = {8'd0, col}; din = d; we_n = 1'b0; cas_n = 1'b0; tick();
    cas_n = 1'b1; we_n = 1'b1; tick();
    ras_n = 1'b1; tick();
  endtask

  task automatic do_read(input logic [2:0] row, input logic [3:0] col,
                         output logic [3:0] d, output logic v1, output logic v2,
                         output logic [3:0] d2);
    addr = {9'd0, row}; ras_n = 1'b0; tick();
    addr = {8'd0, col}; cas_n = 1'b0; tick();
    d = dout; v1 = dout_vld;
    cas_n = 1'b1; tick();
    v2 = dout_vld; d2 = dout;
    ras_n = 1'b1; tick();
  endtask

  task automatic wcbr(input logic [11:0] a);
    cas_n = 1'b0; we_n = 1'b0; tick();
    addr = a; ras_n = 1'b0; tick();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic t_reset;
    check("R10 test_mode", test_mode, 0);
    check("R10 dout", dout, 0);
    check("R10 dout_vld", dout_vld, 0);
  endtask

  task automatic t_normal;
    logic [3:0] d, d2; logic v1, v2;
    do_write(3'd1, 4'd0, 4'hA);
    do_write(3'd1, 4'd1, 4'h5);
    do_write(3'd1, 4'd2, 4'hF);
    do_write(3'd1, 4'd3, 4'h0);
    do_write(3'd3, 4'd0, 4'h3);
    do_write(3'd3, 4'd1, 4'h1);
    do_write(3'd3, 4'd2, 4'h1);
    do_write(3'd3, 4'd3, 4'h1);
    do_read(3'd1, 4'd0, d, v1, v2, d2);
    check("R5 blk0", d, 4'hA);
    check("R9 vld pulse", v1, 1);
    check("R9 vld drop", v2, 0);
    check("R9 dout held", d2, 4'hA);
    do_read(3'd1, 4'd1, d, v1, v2, d2);  check("R5 blk1", d, 4'h5);
    do_read(3'd1, 4'd2, d, v1, v2, d2);  check("R5 blk2", d, 4'hF);
    do_read(3'd1, 4'd3, d, v1, v2, d2);  check("R5 blk3", d, 4'h0);
    do_write(3'd0, 4'd0, 4'h6);
    check("R9 write leaves dout", dout, 4'h0);
  endtask

  task automatic t_entry;
    wcbr(12'h3FE);
    check("R2 pattern miss", test_mode, 0);
    wcbr(12'hBFF);
    check("R1 entry upper bits ignored", test_mode, 1);
  endtask

  task automatic t_test_ops;
    logic [3:0] d, d2; logic v1, v2;
    do_read(3'd1, 4'd0, d, v1, v2, d2);
    check("R4 all pins differ", d, 4'h0);
    check("R8 read keeps mode", test_mode, 1);
    do_read(3'd3, 4'd2, d, v1, v2, d2);
    check("R4 mixed compare", d, 4'hD);
    do_write(3'd2, 4'd4, 4'h6);
    do_read(3'd2, 4'd5, d, v1, v2, d2);
    check("R3 replicated compare", d, 4'hF);
    wcbr(12'h3FF);
    check("R8 wcbr keeps mode", test_mode, 1);
  endtask

  task automatic t_cbr_exit;
    logic [3:0] d, d2; logic v1, v2;
    cas_n = 1'b0; tick();
    ras_n = 1'b0; tick();
    ras_n = 1'b1; cas_n = 1'b1; tick();
    check("R6 cbr exit", test_mode, 0);
    for (int c = 4; c < 8; c++) begin
      do_read(3'd2, 4'(c), d, v1, v2, d2);
      check("R3 all blocks written", d, 4'h6);
    end
  endtask

  task automatic t_rasonly_exit;
    wcbr(12'h3FF);
    check("R1 reentry", test_mode, 1);
    addr = 12'd5; ras_n = 1'b0; tick();
    tick();
    check("R7 mode held while row low", test_mode, 1);
    ras_n = 1'b1; tick();
    check("R7 ras-only exit", test_mode, 0);
  endtask

  task automatic t_hidden_exit;
    logic [3:0] d;
    wcbr(12'h3FF);
    addr = 12'd3; ras_n = 1'b0; tick();
    addr = 12'd0; cas_n = 1'b0; tick();
    d = dout;
    check("R4 hidden read compare", d, 4'hD);
    ras_n = 1'b1; tick();
    check("R6 row rise with cas low keeps mode", test_mode, 1);
    ras_n = 1'b0; tick();
    ras_n = 1'b1; cas_n = 1'b1; tick();
    check("R6 hidden refresh exit", test_mode, 0);
  endtask

  task automatic t_miss_exit;
    wcbr(12'h3FF);
    wcbr(12'h1FF);
    check("R2 miss exits", test_mode, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_normal();
    t_entry();
    t_test_ops();
    t_cbr_exit();
    t_rasonly_exit();
    t_hidden_exit();
    t_miss_exit();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule